// File: doc/BRIEF.md
# Directory Coherence Home Controller

This block is the home-node directory controller of a small distributed shared-memory system. For every memory block homed at this node it records a directory state and a sharer vector with one bit per processor. Caches elsewhere send it read misses, write misses and data write-backs. The controller answers with point-to-point messages addressed to single nodes: data replies, invalidates, fetches and fetch-with-invalidate requests. It never broadcasts. The controller also holds the backing memory for its blocks, and that memory is reset to zero.

Request messages arrive on a valid/ready input. Each carries a message type, a source node, a block address and a data word. Outgoing messages leave on a valid/ready output. Each carries a type, a destination node, a block address and a data word. The controller works on one request at a time. When a block is owned exclusively, the controller sends a fetch to the owner and then waits for that owner's write-back. It stores the returned data in memory before it replies to the requester. Messages are assumed to arrive in the order they were sent, and every requester blocks until it receives its reply.

The control FSM has six states. IDLE accepts a request. DECIDE reads the directory entry and chooses an action. INVAL walks the pending invalidate mask. FETCH issues the fetch or fetch/invalidate. WAIT_WB accepts the owner's write-back. REPLY sends the data reply. The transitions are:
- IDLE→DECIDE on any accepted message.
- DECIDE→REPLY for read misses to Uncached or Shared blocks and write misses to Uncached blocks.
- DECIDE→INVAL for a write miss to a Shared block that has other sharers.
- DECIDE→FETCH for any miss to an Exclusive block.
- DECIDE→IDLE for write-backs and reserved codes.
- INVAL→REPLY after the last invalidate.
- FETCH→WAIT_WB on handshake.
- WAIT_WB→REPLY on the write-back.
- REPLY→IDLE on handshake.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0, every block is Uncached with no sharers, and every memory word is zero.
- R2: A read miss (in_type 0) to an Uncached block produces one data reply (out_type 0) to the requester. The reply carries the block's memory word. The block becomes Shared, with only the requester recorded.
- R3: A read miss to a Shared block adds the requester to the sharers and produces a data reply to the requester. The previous sharers are kept.
- R4: A write miss (in_type 1) to an Uncached block produces a data reply to the requester. The block becomes Exclusive, with the requester as owner.
- R5: A write miss to a Shared block sends one invalidate (out_type 1) to each recorded sharer other than the requester. The invalidates go out one per accepted cycle, in ascending node number. A data reply to the requester follows them. The block becomes Exclusive, owned by the requester.
- R6: A read miss to an Exclusive block sends a fetch (out_type 2) to the owner, then waits for the owner's write-back. The returned word is stored in memory, and a data reply carrying it goes to the requester. The block becomes Shared, with the old owner and the requester recorded.
- R7: A write miss to an Exclusive block sends a fetch/invalidate (out_type 3) to the owner, then waits for the write-back. The returned word is stored in memory and is sent in a data reply to the requester. The block stays Exclusive, with the requester as the new owner.
- R8: A data write-back (in_type 2) to an Exclusive block writes in_data to memory. The block becomes Uncached with no sharers, and the controller sends no message.
- R9: A data write-back to a block that is not Exclusive, and any message with the reserved in_type 3, is accepted and dropped. Neither changes memory, the directory or the output.
- R10: Requests are handled one at a time. in_ready is 0 while an outgoing message is pending. While the controller waits for a fetched block, in_ready is 1 only for a write-back.
- R11: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_type, out_dest, out_addr and out_data stay unchanged.
- R12: Invalidate, fetch and fetch/invalidate messages carry zero in out_data. All outgoing messages carry the request's block address in out_addr.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming message valid |
| in_ready | output | 1 | Controller can accept the incoming message |
| in_type | input | 2 | 0 read miss, 1 write miss, 2 data write-back, 3 reserved |
| in_src | input | NODE_W (3) | Sending node number |
| in_addr | input | ADDR_W (4) | Block address |
| in_data | input | DATA_W (32) | Write-back data |
| out_valid | output | 1 | Outgoing message valid |
| out_ready | input | 1 | Network accepts the outgoing message |
| out_type | output | 2 | 0 data reply, 1 invalidate, 2 fetch, 3 fetch/invalidate |
| out_dest | output | NODE_W (3) | Destination node number |
| out_addr | output | ADDR_W (4) | Block address |
| out_data | output | DATA_W (32) | Reply data, zero for the other types |

## Verification
The bench builds sharer sets in scrambled node order. It then checks that the invalidate walk comes out in ascending order and skips a requester that is already a sharer. A design that scanned in arrival order, or that invalidated the requester, would emit the wrong message sequence. The fetch cases check two things. First, the reply carries the word returned by the owner and not the stale memory word. Second, the directory that results (owner plus reader after a fetch, new owner only after a fetch/invalidate) is exposed by a later request that produces invalidates or fetches only to the nodes that should be recorded. Dropped write-backs and reserved codes are checked by a following read, which must return zero data and must invalidate only the one reader. Backpressure and the input stall during an invalidate walk or a fetch wait are sampled at the ports. A design that let a new request in early, or let the output message change while stalled, would be caught there.

// File: rtl/dir_pkg.sv
package dir_pkg;

    typedef enum logic [1:0] {
        REQ_RD   = 2'd0,
        REQ_WR   = 2'd1,
        REQ_WB   = 2'd2,
        REQ_RSVD = 2'd3
    } req_e;

    typedef enum logic [1:0] {
        RSP_DATA  = 2'd0,
        RSP_INV   = 2'd1,
        RSP_FETCH = 2'd2,
        RSP_FINV  = 2'd3
    } rsp_e;

    typedef enum logic [1:0] {
        DS_UNC = 2'd0,
        DS_SHR = 2'd1,
        DS_EXC = 2'd2
    } dstate_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_INVAL,
        ST_FETCH,
        ST_WAIT_WB,
        ST_REPLY
    } fsm_e;

endpackage

// File: rtl/dir_state_table.sv
module dir_state_table #(
    parameter int NODES  = 8,
    parameter int BLOCKS = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [1:0]        rd_state,
    output logic [NODES-1:0]  rd_sharers,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [1:0]        wr_state,
    input  logic [NODES-1:0]  wr_sharers
);

    logic [1:0]       state_q   [BLOCKS];
    logic [NODES-1:0] sharers_q [BLOCKS];

    for (genvar b = 0; b < BLOCKS; b++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                state_q[b]   <= 2'd0;
                sharers_q[b] <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(b))) begin
                state_q[b]   <= wr_state;
                sharers_q[b] <= wr_sharers;
            end
        end
    end

    assign rd_state   = state_q[rd_addr];
    assign rd_sharers = sharers_q[rd_addr];

endmodule

// File: rtl/dir_backing_mem.sv
module dir_backing_mem #(
    parameter int BLOCKS = 16,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);

    logic [DATA_W-1:0] word_q [BLOCKS];

    for (genvar b = 0; b < BLOCKS; b++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q[b] <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(b))) begin
                word_q[b] <= wr_data;
            end
        end
    end

    assign rd_data = word_q[rd_addr];

endmodule

// File: rtl/dir_lowest_bit.sv
module dir_lowest_bit #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx
);

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
    import dir_pkg::*;
#(
    parameter int NODES  = 8,
    parameter int BLOCKS = 16,
    parameter int DATA_W = 32,
    localparam int NODE_W = $clog2(NODES),
    localparam int ADDR_W = $clog2(BLOCKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_type,
    input  logic [NODE_W-1:0] in_src,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [1:0]        out_type,
    output logic [NODE_W-1:0] out_dest,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data
);

    localparam logic [NODES-1:0] ONE_BIT = NODES'(1);

    fsm_e              st_q, st_nx;
    req_e              req_type_q;
    logic [NODE_W-1:0] req_src_q;
    logic [ADDR_W-1:0] req_addr_q;
    logic [DATA_W-1:0] req_data_q;
    logic [NODES-1:0]  pend_q;
    logic [NODE_W-1:0] owner_q;
    logic              finv_q;

    logic [1:0]        tbl_rd_state;
    logic [NODES-1:0]  tbl_rd_sharers;
    logic              tbl_we;
    logic [1:0]        tbl_wstate;
    logic [NODES-1:0]  tbl_wsharers;
    logic [DATA_W-1:0] mem_rd_data;
    logic              mem_we;
    logic [DATA_W-1:0] mem_wdata;
    logic [NODE_W-1:0] inv_idx;
    logic [NODE_W-1:0] own_idx;

    dstate_e           cur_state;
    logic [NODES-1:0]  src_bit;
    logic [NODES-1:0]  owner_bit;
    logic [NODES-1:0]  others;
    logic              out_fire;
    logic              wb_fire;

    assign cur_state = dstate_e'(tbl_rd_state);
    assign src_bit   = ONE_BIT << req_src_q;
    assign owner_bit = ONE_BIT << owner_q;
    assign others    = tbl_rd_sharers & ~src_bit;
    assign out_fire  = out_valid && out_ready;
    assign wb_fire   = (st_q == ST_WAIT_WB) && in_valid && (req_e'(in_type) == REQ_WB);

    dir_state_table #(
        .NODES (NODES),
        .BLOCKS(BLOCKS),
        .ADDR_W(ADDR_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr   (req_addr_q),
        .rd_state  (tbl_rd_state),
        .rd_sharers(tbl_rd_sharers),
        .wr_en     (tbl_we),
        .wr_addr   (req_addr_q),
        .wr_state  (tbl_wstate),
        .wr_sharers(tbl_wsharers)
    );

    dir_backing_mem #(
        .BLOCKS(BLOCKS),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_addr(req_addr_q),
        .rd_data(mem_rd_data),
        .wr_en  (mem_we),
        .wr_addr(req_addr_q),
        .wr_data(mem_wdata)
    );

    dir_lowest_bit #(
        .N (NODES),
        .IW(NODE_W)
    ) u_inv_scan (
        .vec(pend_q),
        .idx(inv_idx)
    );

    dir_lowest_bit #(
        .N (NODES),
        .IW(NODE_W)
    ) u_own_scan (
        .vec(tbl_rd_sharers),
        .idx(own_idx)
    );

    // next-state selection
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (in_valid) st_nx = ST_DECIDE;
            end
            ST_DECIDE: begin
                unique case (req_type_q)
                    REQ_RD: st_nx = (cur_state == DS_EXC) ? ST_FETCH : ST_REPLY;
                    REQ_WR: begin
                        if (cur_state == DS_EXC)
                            st_nx = ST_FETCH;
                        else if ((cur_state == DS_SHR) && (others != '0))
                            st_nx = ST_INVAL;
                        else
                            st_nx = ST_REPLY;
                    end
                    default: st_nx = ST_IDLE;
                endcase
            end
            ST_INVAL: begin
                if (out_ready && ((pend_q & (pend_q - ONE_BIT)) == '0)) st_nx = ST_REPLY;
            end
            ST_FETCH: begin
                if (out_ready) st_nx = ST_WAIT_WB;
            end
            ST_WAIT_WB: begin
                if (wb_fire) st_nx = ST_REPLY;
            end
            ST_REPLY: begin
                if (out_ready) st_nx = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // state register and request context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            req_type_q <= REQ_RD;
            req_src_q  <= '0;
            req_addr_q <= '0;
            req_data_q <= '0;
            pend_q     <= '0;
            owner_q    <= '0;
            finv_q     <= 1'b0;
        end else begin
            st_q <= st_nx;
            unique case (st_q)
                ST_IDLE: begin
                    if (in_valid) begin
                        req_type_q <= req_e'(in_type);
                        req_src_q  <= in_src;
                        req_addr_q <= in_addr;
                        req_data_q <= in_data;
                    end
                end
                ST_DECIDE: begin
                    pend_q  <= others;
                    owner_q <= own_idx;
                    finv_q  <= (req_type_q == REQ_WR);
                end
                ST_INVAL: begin
                    if (out_ready) pend_q[inv_idx] <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // outputs, directory writes and memory writes
    always_comb begin
        in_ready     = 1'b0;
        out_valid    = 1'b0;
        out_type     = RSP_DATA;
        out_dest     = req_src_q;
        out_addr     = req_addr_q;
        out_data     = '0;
        tbl_we       = 1'b0;
        tbl_wstate   = DS_UNC;
        tbl_wsharers = '0;
        mem_we       = 1'b0;
        mem_wdata    = req_data_q;
        unique case (st_q)
            ST_IDLE: in_ready = 1'b1;
            ST_DECIDE: begin
                unique case (req_type_q)
                    REQ_RD: begin
                        if (cur_state == DS_UNC) begin
                            tbl_we       = 1'b1;
                            tbl_wstate   = DS_SHR;
                            tbl_wsharers = src_bit;
                        end else if (cur_state == DS_SHR) begin
                            tbl_we       = 1'b1;
                            tbl_wstate   = DS_SHR;
                            tbl_wsharers = tbl_rd_sharers | src_bit;
                        end
                    end
                    REQ_WR: begin
                        if (cur_state != DS_EXC) begin
                            tbl_we       = 1'b1;
                            tbl_wstate   = DS_EXC;
                            tbl_wsharers = src_bit;
                        end
                    end
                    REQ_WB: begin
                        if (cur_state == DS_EXC) begin
                            tbl_we       = 1'b1;
                            tbl_wstate   = DS_UNC;
                            tbl_wsharers = '0;
                            mem_we       = 1'b1;
                            mem_wdata    = req_data_q;
                        end
                    end
                    default: ;
                endcase
            end
            ST_INVAL: begin
                out_valid = 1'b1;
                out_type  = RSP_INV;
                out_dest  = inv_idx;
            end
            ST_FETCH: begin
                out_valid = 1'b1;
                out_type  = finv_q ? RSP_FINV : RSP_FETCH;
                out_dest  = owner_q;
            end
            ST_WAIT_WB: begin
                in_ready = (req_e'(in_type) == REQ_WB);
                if (wb_fire) begin
                    mem_we       = 1'b1;
                    mem_wdata    = in_data;
                    tbl_we       = 1'b1;
                    tbl_wstate   = finv_q ? DS_EXC : DS_SHR;
                    tbl_wsharers = finv_q ? src_bit : (src_bit | owner_bit);
                end
            end
            ST_REPLY: begin
                out_valid = 1'b1;
                out_type  = RSP_DATA;
                out_dest  = req_src_q;
                out_data  = mem_rd_data;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dir_home_ctrl_chk.sv
module dir_home_ctrl_chk #(
    parameter int NODE_W = 3,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [1:0]        out_type,
    input logic [NODE_W-1:0] out_dest,
    input logic [ADDR_W-1:0] out_addr,
    input logic [DATA_W-1:0] out_data
);

    // R11
    hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_type) && $stable(out_dest)
                                       && $stable(out_addr) && $stable(out_data)));

    // R10
    one_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R5
    inval_ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_type == 2'd1)
        |=> (!(out_valid && out_type == 2'd1) || (out_dest > $past(out_dest))));

    // R6
    fetch_then_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_type[1]) |=> !out_valid);

    // R12
    ctrl_msg_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_type != 2'd0) |-> (out_data == '0));

endmodule

bind dir_home_ctrl dir_home_ctrl_chk #(
    .NODE_W(NODE_W),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_type (out_type),
    .out_dest (out_dest),
    .out_addr (out_addr),
    .out_data (out_data)
);

// File: tb/dir_home_ctrl_tb.sv
`timescale 1ns/1ps
module dir_home_ctrl_tb;

    localparam int NODE_W = 3;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [1:0]        in_type = '0;
    logic [NODE_W-1:0] in_src = '0;
    logic [ADDR_W-1:0] in_addr = '0;
    logic [DATA_W-1:0] in_data = '0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [1:0]        out_type;
    logic [NODE_W-1:0] out_dest;
    logic [ADDR_W-1:0] out_addr;
    logic [DATA_W-1:0] out_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic [1:0]        log_type [64];
    logic [NODE_W-1:0] log_dest [64];
    logic [ADDR_W-1:0] log_addr [64];
    logic [DATA_W-1:0] log_data [64];
    int log_cnt = 0;
    int rd_ptr = 0;

    always #2 clk = ~clk;

    dir_home_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_type(in_type),
        .in_src(in_src), .in_addr(in_addr), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_type(out_type),
        .out_dest(out_dest), .out_addr(out_addr), .out_data(out_data)
    );

    // record each message that will be taken at the next edge
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready && log_cnt < 64) begin
            log_type[log_cnt] = out_type;
            log_dest[log_cnt] = out_dest;
            log_addr[log_cnt] = out_addr;
            log_data[log_cnt] = out_data;
            log_cnt++;
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
            finish_run();
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] t, input int src, input int addr, input logic [DATA_W-1:0] d);
        @(posedge clk); #1;
        in_valid = 1'b1;
        in_type  = t;
        in_src   = NODE_W'(src);
        in_addr  = ADDR_W'(addr);
        in_data  = d;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic expect_msg(input string tag, input logic [1:0] t, input int dest,
                              input int addr, input logic [DATA_W-1:0] d);
        int waited = 0;
        while (log_cnt <= rd_ptr && waited < 60) begin
            @(negedge clk);
            waited++;
        end
        if (log_cnt <= rd_ptr) begin
            check(1'b0, {tag, " missing message"}, 64'(0), {t, 8'(dest), 8'(addr)});
        end else begin
            check({log_type[rd_ptr], log_dest[rd_ptr], log_addr[rd_ptr], log_data[rd_ptr]}
                  == {t, NODE_W'(dest), ADDR_W'(addr), d}, tag,
                  {log_type[rd_ptr], 8'(log_dest[rd_ptr]), 8'(log_addr[rd_ptr]), log_data[rd_ptr]},
                  {t, 8'(dest), 8'(addr), d});
            rd_ptr++;
        end
    endtask

    task automatic expect_quiet(input string tag);
        repeat (8) @(negedge clk);
        check(log_cnt == rd_ptr, {tag, " no extra message"}, 64'(log_cnt), 64'(rd_ptr));
    endtask

    // R1: reset state
    task automatic t_reset();
        @(negedge clk);
        check(in_ready == 1'b1, "R1 in_ready after reset", 64'(in_ready), 64'd1);
        check(out_valid == 1'b0, "R1 out_valid after reset", 64'(out_valid), 64'd0);
    endtask

    // R2 R3 R5 R10: sharers gathered out of order, requester already sharing
    task automatic t_shared_walk();
        send(2'd0, 6, 2, '0);
        expect_msg("R2 reply to first reader", 2'd0, 6, 2, '0);
        send(2'd0, 1, 2, '0);
        expect_msg("R3 reply to second reader", 2'd0, 1, 2, '0);
        send(2'd0, 3, 2, '0);
        expect_msg("R3 reply to third reader", 2'd0, 3, 2, '0);
        send(2'd1, 3, 2, '0);
        while (!out_valid) @(negedge clk);
        check(in_ready == 1'b0, "R10 input stalled during invalidates", 64'(in_ready), 64'd0);
        expect_msg("R5 invalidate lowest sharer", 2'd1, 1, 2, '0);
        expect_msg("R5 invalidate next sharer", 2'd1, 6, 2, '0);
        expect_msg("R5 reply after invalidates", 2'd0, 3, 2, '0);
        expect_quiet("R5");
    endtask

    // R4 R8: exclusive then write-back, later read sees written data
    task automatic t_writeback();
        send(2'd1, 2, 5, '0);
        expect_msg("R4 reply to writer", 2'd0, 2, 5, '0);
        send(2'd2, 2, 5, 32'hA5A5_0001);
        expect_quiet("R8 write-back silent");
        send(2'd0, 4, 5, '0);
        expect_msg("R8 read returns written word", 2'd0, 4, 5, 32'hA5A5_0001);
        expect_quiet("R8 block was uncached");
    endtask

    // R9: dropped write-back and reserved code
    task automatic t_ignored();
        send(2'd2, 2, 11, 32'h0000_1234);
        send(2'd3, 1, 11, 32'hFFFF_FFFF);
        expect_quiet("R9 dropped messages silent");
        send(2'd0, 0, 11, '0);
        expect_msg("R9 memory unchanged", 2'd0, 0, 11, '0);
        send(2'd1, 7, 11, '0);
        expect_msg("R9 only the reader invalidated", 2'd1, 0, 11, '0);
        expect_msg("R9 reply to writer", 2'd0, 7, 11, '0);
        expect_quiet("R9");
    endtask

    // R6 R10 R12: read miss to an owned block
    task automatic t_fetch_read();
        send(2'd1, 0, 7, '0);
        expect_msg("R4 reply to owner", 2'd0, 0, 7, '0);
        send(2'd0, 4, 7, '0);
        expect_msg("R6 R12 fetch to owner", 2'd2, 0, 7, '0);
        @(posedge clk); #1;
        in_valid = 1'b1; in_type = 2'd0; in_src = 3'd5; in_addr = 4'd7;
        @(negedge clk);
        check(in_ready == 1'b0, "R10 read refused while waiting", 64'(in_ready), 64'd0);
        @(posedge clk); #1;
        in_valid = 1'b0;
        send(2'd2, 0, 7, 32'hBEEF_0007);
        expect_msg("R6 reply with fetched word", 2'd0, 4, 7, 32'hBEEF_0007);
        send(2'd1, 2, 7, '0);
        expect_msg("R6 old owner now sharer", 2'd1, 0, 7, '0);
        expect_msg("R6 reader now sharer", 2'd1, 4, 7, '0);
        expect_msg("R6 reply keeps memory", 2'd0, 2, 7, 32'hBEEF_0007);
        expect_quiet("R6");
    endtask

    // R7: write miss to an owned block
    task automatic t_fetch_write();
        send(2'd1, 1, 9, '0);
        expect_msg("R4 reply to first owner", 2'd0, 1, 9, '0);
        send(2'd1, 5, 9, '0);
        expect_msg("R7 fetch/invalidate to owner", 2'd3, 1, 9, '0);
        send(2'd2, 1, 9, 32'hC0DE_0009);
        expect_msg("R7 reply with returned word", 2'd0, 5, 9, 32'hC0DE_0009);
        send(2'd0, 6, 9, '0);
        expect_msg("R7 new owner is fetched", 2'd2, 5, 9, '0);
        send(2'd2, 5, 9, 32'h0000_0055);
        expect_msg("R7 reply after second fetch", 2'd0, 6, 9, 32'h0000_0055);
        expect_quiet("R7");
    endtask

    // R11: reply held under backpressure
    task automatic t_backpressure();
        logic [1:0]        t0;
        logic [NODE_W-1:0] d0;
        logic [ADDR_W-1:0] a0;
        logic [DATA_W-1:0] w0;
        out_ready = 1'b0;
        send(2'd0, 3, 13, '0);
        while (!out_valid) @(negedge clk);
        t0 = out_type; d0 = out_dest; a0 = out_addr; w0 = out_data;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b1, "R11 valid held", 64'(out_valid), 64'd1);
        check({out_type, out_dest, out_addr, out_data} == {t0, d0, a0, w0}, "R11 fields stable",
              64'({out_type, out_dest, out_addr}), 64'({t0, d0, a0}));
        check(in_ready == 1'b0, "R10 input stalled under backpressure", 64'(in_ready), 64'd0);
        @(posedge clk); #1;
        out_ready = 1'b1;
        expect_msg("R11 reply delivered", 2'd0, 3, 13, '0);
        expect_quiet("R11");
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_shared_walk();
        t_writeback();
        t_ignored();
        t_fetch_read();
        t_fetch_write();
        t_backpressure();
        done = 1'b1;
        finish_run();
    end

endmodule